// File: doc/BRIEF.md
# Write-Path Flush Trigger Controller

This block produces the flush request for a streaming write path that feeds an external memory. While the request is high, a downstream flusher throws away arriving beats instead of buffering them. The block runs entirely in the write clock domain. It watches the memory driver's control lines (enable, write-not-read, done), an optional arm input, and the framing signals of the incoming stream: valid, start of packet, sync and channel.

Two parameters set the behaviour. `EXT_ARM` picks what raises the request. When it is 0, the request goes high whenever the driver cannot accept a write. When it is 1, a rising edge on the arm input raises the request and the driver lines are ignored. `STOP_MODE` picks the beat that ends a flush. The choices are any valid beat, a valid start-of-packet beat, a valid start-of-packet beat that also carries sync, or a valid start-of-packet beat on the channel set by `START_CHAN`.

Top module: `wr_flush_trigger`

## Requirements
- R1: While reset is high, and in the first cycle after reset is released, the flush output is 1 in every configuration.
- R2: The flush output is a register. It changes only on the clock edge after the cycle in which its cause (raise or stop) was sampled on the inputs.
- R3: With EXT_ARM=0, the driver is ready when drv_en=1, drv_wr=1 and drv_done=0. In any cycle where it is not ready, the flush output is 1 from the next cycle on. This holds whatever the stream carries in that cycle.
- R4: With EXT_ARM=1, a cycle where arm_in is 1 after being 0 in the previous cycle sets the flush output on the next edge. The drv_en, drv_wr and drv_done inputs have no effect on the output.
- R5: With STOP_MODE=STOP_ANY, a beat with st_valid=1 ends a flush, provided that raising is not active in the same cycle.
- R6: With STOP_MODE=STOP_SOP, only a beat with st_valid=1 and st_sop=1 ends a flush.
- R7: With STOP_MODE=STOP_SOP_SYNC, only a beat with st_valid=1, st_sop=1 and st_sync=1 ends a flush. A beat with sop but no sync, or with sync but no sop, leaves flushing on.
- R8: With STOP_MODE=STOP_SOP_CHAN, only a valid sop beat with st_chan equal to START_CHAN ends a flush. Sop beats on other channels leave flushing on.
- R9: Once the output is 0, stream beats do not bring it back to 1. With EXT_ARM=0 it stays 0 while the driver remains ready.
- R10: With EXT_ARM=1, holding arm_in at 1 over several cycles raises the output only once. It does not re-raise it after a stop.
- R11: A cycle with st_valid=0 never ends a flush, whatever the values of sop, sync and channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write clock |
| rst | input | 1 | Synchronous active-high reset |
| drv_en | input | 1 | Memory driver enabled |
| drv_wr | input | 1 | Driver direction, 1 = write |
| drv_done | input | 1 | Driver has finished its transfer |
| arm_in | input | 1 | External arm, acts on its rising edge (EXT_ARM=1 only) |
| st_valid | input | 1 | Stream beat valid |
| st_sop | input | 1 | Stream beat starts a packet |
| st_sync | input | 1 | Stream beat carries sync |
| st_chan | input | CHAN_W | Stream beat channel number |
| flush_o | output | 1 | Registered flush request |

## Verification
The assertions assume that all inputs are synchronous to the write clock and settle before each rising edge. They also assume that arm_in is held low during reset, so the first edge after reset is a genuine rise, and that st_chan stays below NUM_CHAN. The bench changes every input only on the falling clock edge and keeps arm_in at 0 while reset is high. It drives four instances, one per stop mode, from the same lines, and uses only channel numbers 0 to 3 against a channel count of four.

// File: rtl/flush_trig_pkg.sv
package flush_trig_pkg;

  // Beat condition that ends an active flush
  typedef enum logic [1:0] {
    STOP_ANY      = 2'd0,
    STOP_SOP      = 2'd1,
    STOP_SOP_SYNC = 2'd2,
    STOP_SOP_CHAN = 2'd3
  } stop_mode_e;

endpackage

// File: rtl/ft_stop_detect.sv
module ft_stop_detect
  import flush_trig_pkg::*;
#(
  parameter stop_mode_e STOP_MODE  = STOP_ANY,
  parameter int         CHAN_W     = 1,
  parameter int         START_CHAN = 0
) (
  input  logic              valid_i,
  input  logic              sop_i,
  input  logic              sync_i,
  input  logic [CHAN_W-1:0] chan_i,
  output logic              hit_o
);

  localparam logic [CHAN_W-1:0] MatchChan = CHAN_W'(START_CHAN);

  logic chan_eq;
  assign chan_eq = (chan_i == MatchChan);

  always_comb begin
    unique case (STOP_MODE)
      STOP_SOP:      hit_o = valid_i & sop_i;
      STOP_SOP_SYNC: hit_o = valid_i & sop_i & sync_i;
      STOP_SOP_CHAN: hit_o = valid_i & sop_i & chan_eq;
      default:       hit_o = valid_i;
    endcase
  end

endmodule

// File: rtl/ft_arm_source.sv
module ft_arm_source #(
  parameter bit EXT_ARM = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic drv_en,
  input  logic drv_wr,
  input  logic drv_done,
  input  logic arm_in,
  output logic set_req_o,
  output logic clr_allow_o
);

  logic drv_ready;
  logic arm_prev_q;
  logic arm_rise;

  assign drv_ready = drv_en & drv_wr & ~drv_done;

  always_ff @(posedge clk) begin
    if (rst) arm_prev_q <= 1'b0;
    else     arm_prev_q <= arm_in;
  end

  assign arm_rise = arm_in & ~arm_prev_q;

  assign set_req_o   = EXT_ARM ? arm_rise : ~drv_ready;
  assign clr_allow_o = EXT_ARM ? 1'b1     : drv_ready;

  // R10
  level_no_rearm_chk: assert property (@(posedge clk) disable iff (rst)
    (arm_prev_q && arm_in) |-> !arm_rise);

endmodule

// File: rtl/wr_flush_trigger.sv
module wr_flush_trigger
  import flush_trig_pkg::*;
#(
  parameter bit         EXT_ARM    = 1'b0,
  parameter stop_mode_e STOP_MODE  = STOP_ANY,
  parameter int         NUM_CHAN   = 4,
  parameter int         START_CHAN = 0,
  localparam int        CHAN_W     = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              drv_en,
  input  logic              drv_wr,
  input  logic              drv_done,
  input  logic              arm_in,
  input  logic              st_valid,
  input  logic              st_sop,
  input  logic              st_sync,
  input  logic [CHAN_W-1:0] st_chan,
  output logic              flush_o
);

  logic set_req;
  logic clr_allow;
  logic stop_hit;
  logic flush_q;

  ft_arm_source #(.EXT_ARM(EXT_ARM)) arm_i (
    .clk        (clk),
    .rst        (rst),
    .drv_en     (drv_en),
    .drv_wr     (drv_wr),
    .drv_done   (drv_done),
    .arm_in     (arm_in),
    .set_req_o  (set_req),
    .clr_allow_o(clr_allow)
  );

  ft_stop_detect #(
    .STOP_MODE (STOP_MODE),
    .CHAN_W    (CHAN_W),
    .START_CHAN(START_CHAN)
  ) stop_i (
    .valid_i(st_valid),
    .sop_i  (st_sop),
    .sync_i (st_sync),
    .chan_i (st_chan),
    .hit_o  (stop_hit)
  );

  always_ff @(posedge clk) begin
    if (rst)                             flush_q <= 1'b1;
    else if (set_req)                    flush_q <= 1'b1;
    else if (clr_allow && stop_hit)      flush_q <= 1'b0;
  end

  assign flush_o = flush_q;

  // R1
  reset_flush_chk: assert property (@(posedge clk) rst |=> flush_o);

  // R2
  change_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(flush_o) |-> $past(set_req || (clr_allow && stop_hit)));

  // R11
  no_valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (flush_o && !st_valid) |=> flush_o);

  // R9
  idle_stays_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!flush_o && !set_req) |=> !flush_o);

  generate
    if (EXT_ARM) begin : g_ext
      // R4
      rise_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (arm_in && !flush_o && set_req) |=> flush_o);
    end else begin : g_drv
      // R3
      not_ready_flush_chk: assert property (@(posedge clk) disable iff (rst)
        !(drv_en && drv_wr && !drv_done) |=> flush_o);
    end
  endgenerate

endmodule

// File: tb/wr_flush_trigger_tb_top.sv
module wr_flush_trigger_tb_top;
  import flush_trig_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic drv_en = 1'b0, drv_wr = 1'b0, drv_done = 1'b0, arm_in = 1'b0;
  logic st_valid = 1'b0, st_sop = 1'b0, st_sync = 1'b0;
  logic [1:0] st_chan = 2'd0;
  logic [3:0] flush_v;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  // inst 0: any valid, driver; 1: sop, driver; 2: sop+sync, external arm; 3: sop+chan 2, driver
  wr_flush_trigger #(.EXT_ARM(1'b0), .STOP_MODE(STOP_ANY), .NUM_CHAN(4)) dut_i (
    .clk(clk), .rst(rst), .drv_en(drv_en), .drv_wr(drv_wr), .drv_done(drv_done),
    .arm_in(arm_in), .st_valid(st_valid), .st_sop(st_sop), .st_sync(st_sync),
    .st_chan(st_chan), .flush_o(flush_v[0]));
  wr_flush_trigger #(.EXT_ARM(1'b0), .STOP_MODE(STOP_SOP), .NUM_CHAN(4)) dut_sop_i (
    .clk(clk), .rst(rst), .drv_en(drv_en), .drv_wr(drv_wr), .drv_done(drv_done),
    .arm_in(arm_in), .st_valid(st_valid), .st_sop(st_sop), .st_sync(st_sync),
    .st_chan(st_chan), .flush_o(flush_v[1]));
  wr_flush_trigger #(.EXT_ARM(1'b1), .STOP_MODE(STOP_SOP_SYNC), .NUM_CHAN(4)) dut_sync_i (
    .clk(clk), .rst(rst), .drv_en(drv_en), .drv_wr(drv_wr), .drv_done(drv_done),
    .arm_in(arm_in), .st_valid(st_valid), .st_sop(st_sop), .st_sync(st_sync),
    .st_chan(st_chan), .flush_o(flush_v[2]));
  wr_flush_trigger #(.EXT_ARM(1'b0), .STOP_MODE(STOP_SOP_CHAN), .NUM_CHAN(4),
                     .START_CHAN(2)) dut_chan_i (
    .clk(clk), .rst(rst), .drv_en(drv_en), .drv_wr(drv_wr), .drv_done(drv_done),
    .arm_in(arm_in), .st_valid(st_valid), .st_sop(st_sop), .st_sync(st_sync),
    .st_chan(st_chan), .flush_o(flush_v[3]));

  typedef struct {
    logic [3:0] exp;
    string      tag;
  } item_t;

  item_t sb_q[$];
  logic [3:0] model = 4'hF;
  logic arm_prev_m = 1'b0;

  // Driver: applies one cycle of stimulus and pushes the expected outputs
  task automatic step(input logic r, input logic en, input logic wr, input logic dn,
                      input logic arm, input logic v, input logic sop, input logic sy,
                      input logic [1:0] ch, input string tag);
    logic rdy, rise;
    logic [3:0] hit;
    item_t it;
    @(negedge clk);
    rst = r; drv_en = en; drv_wr = wr; drv_done = dn; arm_in = arm;
    st_valid = v; st_sop = sop; st_sync = sy; st_chan = ch;
    rdy = en & wr & ~dn;
    rise = arm & ~arm_prev_m;
    hit[0] = v;
    hit[1] = v & sop;
    hit[2] = v & sop & sy;
    hit[3] = v & sop & (ch == 2'd2);
    if (r) begin
      model = 4'hF;
      arm_prev_m = 1'b0;
    end else begin
      for (int k = 0; k < 4; k++) begin
        if (k == 2) begin
          if (rise) model[k] = 1'b1;
          else if (model[k] && hit[k]) model[k] = 1'b0;
        end else begin
          if (!rdy) model[k] = 1'b1;
          else if (model[k] && hit[k]) model[k] = 1'b0;
        end
      end
      arm_prev_m = arm;
    end
    it.exp = model;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  // Monitor: compares outputs one edge after each pushed stimulus
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        for (int k = 0; k < 4; k++) begin
          n_checks++;
          if (flush_v[k] !== it.exp[k]) begin
            n_fail++;
            $display("FAIL %s inst%0d: flush actual %b expected %b", it.tag, k,
                     flush_v[k], it.exp[k]);
          end
        end
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    step(1, 1, 1, 0, 0, 0, 0, 0, 2'd0, "R1");
    step(1, 1, 1, 0, 0, 0, 0, 0, 2'd0, "R1");
    // R11 idle with framing bits set but no valid
    step(0, 1, 1, 0, 0, 0, 1, 1, 2'd2, "R11");
    step(0, 1, 1, 0, 0, 0, 0, 0, 2'd0, "R11");
    // R5 plain valid ends only the any-valid instance; R2 timing
    step(0, 1, 1, 0, 0, 1, 0, 0, 2'd0, "R5 R2");
    // R6 sop on channel 1 ends sop instance only
    step(0, 1, 1, 0, 0, 1, 1, 0, 2'd1, "R6");
    // R8 sop on start channel
    step(0, 1, 1, 0, 0, 1, 1, 0, 2'd2, "R8");
    // R7 sop with sync
    step(0, 1, 1, 0, 0, 1, 1, 1, 2'd0, "R7");
    // R9 beats while ready keep everything low
    step(0, 1, 1, 0, 0, 1, 1, 1, 2'd2, "R9");
    step(0, 1, 1, 0, 0, 1, 0, 0, 2'd3, "R9");
    // R3 not ready raises; a stop beat in the same cycle does not win
    step(0, 0, 1, 0, 0, 1, 1, 1, 2'd2, "R3");
    step(0, 1, 1, 0, 0, 0, 0, 0, 2'd0, "R3");
    step(0, 1, 0, 0, 0, 1, 1, 1, 2'd2, "R3");
    step(0, 1, 1, 1, 0, 1, 1, 1, 2'd2, "R3");
    // R5 any-valid stops again once ready
    step(0, 1, 1, 0, 0, 1, 0, 0, 2'd0, "R5");
    // R4 arm rise raises external instance
    step(0, 1, 1, 0, 1, 0, 0, 0, 2'd0, "R4");
    // R7 arm held high, sync sop stops it
    step(0, 1, 1, 0, 1, 1, 1, 1, 2'd3, "R7");
    // R10 level arm does not re-raise
    step(0, 1, 1, 0, 1, 0, 0, 0, 2'd0, "R10");
    step(0, 1, 1, 0, 1, 0, 0, 0, 2'd0, "R10");
    // R4 driver not ready leaves external instance alone
    step(0, 0, 0, 1, 0, 0, 0, 0, 2'd0, "R4");
    step(0, 1, 1, 0, 1, 0, 0, 0, 2'd0, "R4");
    // R8 wrong channel keeps flushing, right channel ends it
    step(0, 1, 1, 0, 0, 1, 1, 0, 2'd3, "R8");
    step(0, 1, 1, 0, 0, 1, 1, 0, 2'd2, "R8");
    // R7 sync without sop, then R11 no valid
    step(0, 1, 1, 0, 0, 1, 0, 1, 2'd0, "R7");
    step(0, 1, 1, 0, 0, 0, 1, 1, 2'd0, "R11");
    step(0, 1, 1, 0, 0, 1, 1, 1, 2'd1, "R7");
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule